// File: doc/BRIEF.md
# Interrupt Distributor State Tracker

This block holds the per-interrupt bookkeeping of a multi-processor interrupt distributor. Each interrupt has five per-processor bitmasks: enable, latched pending, active, line level and group. It also has two per-interrupt flags. The trigger flag selects edge-sensitive (1) or level-sensitive (0) behaviour. The spread flag makes an acknowledge clear pending on every processor. A priority store sits beside the bitmasks. Interrupts below `NINT` keep one priority byte per processor. Interrupts at or above `NINT` share a single byte across all processors.

Surrounding logic drives single-cycle command ports. Separate set and clear ports act on a chosen state kind under a processor mask. Other ports acknowledge an interrupt for one processor, update line levels, write the two flags, write a priority byte and write the two group enables. Every command is sampled on a rising clock edge. Its effect is visible on the query outputs from the next cycle on.

The query outputs are combinational. They describe one interrupt for one processor: effective pending, active, enabled, group, priority, and whether the interrupt may be forwarded. When the revision input is zero, the block runs in legacy mode and the line level plays no part in pending.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every bitmask, both flags, every priority byte and both group enables are zero. All query outputs then read zero.
- R2: Set and clear commands select a state kind with the code 0 enable, 1 pending, 2 active, 3 group. They change only the bits of processors whose mask bit is 1. The new value shows on the query outputs one cycle after the command.
- R3: When one cycle brings both a set and a clear to the same interrupt, kind and processor, the bit ends cleared. This covers set commands and edge captures on the set side, and clear commands and acknowledges on the clear side.
- R4: With a nonzero revision input, a processor sees the interrupt as pending if its latched pending bit is 1. It also sees it as pending if the interrupt is level-sensitive and that processor's line level is 1.
- R5: With the revision input equal to zero, effective pending equals the latched pending bit, and the line level has no effect.
- R6: An acknowledge clears the latched pending bit of all processors when the interrupt's spread flag is 1, and only the acknowledging processor's bit otherwise. A level-sensitive interrupt whose line is still 1 reads as pending afterwards when the revision is nonzero.
- R7: For an edge-sensitive interrupt, a 0-to-1 change of a processor's line level sets that processor's latched pending bit. This happens only if the interrupt is enabled for that processor in the cycle of the change. Level-sensitive interrupts never latch from the line.
- R8: A priority write to an interrupt below `NINT` sets only the byte of the named processor. A write to an interrupt at or above `NINT` sets the shared byte, whatever processor index it carries, and every processor reads that byte back.
- R9: Group-enable bit 0 enables group 0 and bit 1 enables group 1. The forward output is 1 exactly when the interrupt is effectively pending, enabled for the queried processor, and its group for that processor is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev_code | input | 8 | Revision code; zero selects legacy pending |
| ctl_vld | input | 1 | Write group enables |
| ctl_data | input | 2 | Group enables (bit 0 group 0, bit 1 group 1) |
| set_vld | input | 1 | Set command valid |
| set_kind | input | 2 | Set kind: 0 enable, 1 pending, 2 active, 3 group |
| set_irq | input | 6 | Set target interrupt |
| set_mask | input | 4 | Set processor mask |
| clr_vld | input | 1 | Clear command valid |
| clr_kind | input | 2 | Clear kind (same codes) |
| clr_irq | input | 6 | Clear target interrupt |
| clr_mask | input | 4 | Clear processor mask |
| ack_vld | input | 1 | Acknowledge valid |
| ack_irq | input | 6 | Acknowledged interrupt |
| ack_cpu | input | 2 | Acknowledging processor |
| lvl_vld | input | 1 | Line level update valid |
| lvl_irq | input | 6 | Line level target interrupt |
| lvl_mask | input | 4 | Processors whose line is updated |
| lvl_val | input | 1 | New line level |
| cfg_vld | input | 1 | Flag write valid |
| cfg_irq | input | 6 | Flag write target interrupt |
| cfg_edge | input | 1 | Trigger flag, 1 = edge-sensitive |
| cfg_model | input | 1 | Spread flag for acknowledge |
| pri_vld | input | 1 | Priority write valid |
| pri_irq | input | 6 | Priority target interrupt |
| pri_cpu | input | 2 | Priority target processor |
| pri_val | input | 8 | Priority value |
| q_irq | input | 6 | Queried interrupt |
| q_cpu | input | 2 | Queried processor |
| q_pending | output | 1 | Effective pending |
| q_active | output | 1 | Active bit |
| q_enabled | output | 1 | Enable bit |
| q_group | output | 1 | Group bit |
| q_prio | output | 8 | Priority byte |
| q_fwd | output | 1 | Forwardable |

## Verification
The bench builds the block with its defaults: 4 processors, 64 interrupts and 32 banked interrupts. This puts both priority regions, every mask pattern and the spread-flag acknowledge within reach. Random traffic draws its interrupts from a small pool on each side of the banked boundary. Set, clear, acknowledge and line commands therefore collide on one interrupt often, which exercises clear precedence and edge capture under enable. Revision zero is switched in from time to time, so legacy and level-combined pending are both compared against the behavioural model.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    typedef enum logic [1:0] {
        K_EN   = 2'd0,
        K_PEND = 2'd1,
        K_ACT  = 2'd2,
        K_GRP  = 2'd3
    } st_kind_e;

    localparam int unsigned LEGACY_REV = 0;

endpackage

// File: rtl/irq_cell_bank.sv
module irq_cell_bank
    import irq_trk_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NIRQ  = 64,
    parameter int IRQ_W = $clog2(NIRQ),
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_vld,
    input  st_kind_e                    set_kind,
    input  logic [IRQ_W-1:0]            set_irq,
    input  logic [NCPU-1:0]             set_mask,
    input  logic                        clr_vld,
    input  st_kind_e                    clr_kind,
    input  logic [IRQ_W-1:0]            clr_irq,
    input  logic [NCPU-1:0]             clr_mask,
    input  logic                        ack_vld,
    input  logic [IRQ_W-1:0]            ack_irq,
    input  logic [CPU_W-1:0]            ack_cpu,
    input  logic                        lvl_vld,
    input  logic [IRQ_W-1:0]            lvl_irq,
    input  logic [NCPU-1:0]             lvl_mask,
    input  logic                        lvl_val,
    input  logic                        cfg_vld,
    input  logic [IRQ_W-1:0]            cfg_irq,
    input  logic                        cfg_edge,
    input  logic                        cfg_model,
    output logic [NIRQ-1:0][NCPU-1:0]   st_en,
    output logic [NIRQ-1:0][NCPU-1:0]   st_pend,
    output logic [NIRQ-1:0][NCPU-1:0]   st_act,
    output logic [NIRQ-1:0][NCPU-1:0]   st_lvl,
    output logic [NIRQ-1:0][NCPU-1:0]   st_grp,
    output logic [NIRQ-1:0]             st_edge,
    output logic [NIRQ-1:0]             st_model
);

    localparam logic [NCPU-1:0] ALL_CPUS = {NCPU{1'b1}};

    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
        localparam logic [IRQ_W-1:0] ID = IRQ_W'(i);

        logic [NCPU-1:0] en_r, pd_r, ac_r, lv_r, gp_r;
        logic            edge_r, model_r;
        logic            set_hit, clr_hit, ack_hit, lvl_hit, cfg_hit;
        logic [NCPU-1:0] s_en, s_pd, s_ac, s_gp;
        logic [NCPU-1:0] c_en, c_pd, c_ac, c_gp;
        logic [NCPU-1:0] ack_clr, lvl_nx, rise;

        always_comb begin
            set_hit = set_vld && (set_irq == ID);
            clr_hit = clr_vld && (clr_irq == ID);
            ack_hit = ack_vld && (ack_irq == ID);
            lvl_hit = lvl_vld && (lvl_irq == ID);
            cfg_hit = cfg_vld && (cfg_irq == ID);

            s_en = (set_hit && set_kind == K_EN)   ? set_mask : '0;
            s_pd = (set_hit && set_kind == K_PEND) ? set_mask : '0;
            s_ac = (set_hit && set_kind == K_ACT)  ? set_mask : '0;
            s_gp = (set_hit && set_kind == K_GRP)  ? set_mask : '0;
            c_en = (clr_hit && clr_kind == K_EN)   ? clr_mask : '0;
            c_pd = (clr_hit && clr_kind == K_PEND) ? clr_mask : '0;
            c_ac = (clr_hit && clr_kind == K_ACT)  ? clr_mask : '0;
            c_gp = (clr_hit && clr_kind == K_GRP)  ? clr_mask : '0;

            ack_clr = '0;
            if (ack_hit) begin
                ack_clr = model_r ? ALL_CPUS : (NCPU'(1) << ack_cpu);
            end

            lvl_nx = lv_r;
            if (lvl_hit) begin
                lvl_nx = lvl_val ? (lv_r | lvl_mask) : (lv_r & ~lvl_mask);
            end

            rise = lvl_nx & ~lv_r & en_r & {NCPU{edge_r}};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_r    <= '0;
                pd_r    <= '0;
                ac_r    <= '0;
                lv_r    <= '0;
                gp_r    <= '0;
                edge_r  <= 1'b0;
                model_r <= 1'b0;
            end else begin
                en_r <= (en_r | s_en) & ~c_en;
                pd_r <= (pd_r | s_pd | rise) & ~(c_pd | ack_clr);
                ac_r <= (ac_r | s_ac) & ~c_ac;
                gp_r <= (gp_r | s_gp) & ~c_gp;
                lv_r <= lvl_nx;
                if (cfg_hit) begin
                    edge_r  <= cfg_edge;
                    model_r <= cfg_model;
                end
            end
        end

        assign st_en[i]    = en_r;
        assign st_pend[i]  = pd_r;
        assign st_act[i]   = ac_r;
        assign st_lvl[i]   = lv_r;
        assign st_grp[i]   = gp_r;
        assign st_edge[i]  = edge_r;
        assign st_model[i] = model_r;
    end

endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store #(
    parameter int NCPU   = 4,
    parameter int NIRQ   = 64,
    parameter int NINT   = 32,
    parameter int PRIO_W = 8,
    parameter int IRQ_W  = $clog2(NIRQ),
    parameter int CPU_W  = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [IRQ_W-1:0]  wr_irq,
    input  logic [CPU_W-1:0]  wr_cpu,
    input  logic [PRIO_W-1:0] wr_val,
    input  logic [IRQ_W-1:0]  rd_irq,
    input  logic [CPU_W-1:0]  rd_cpu,
    output logic [PRIO_W-1:0] rd_val
);

    localparam int NSHR = NIRQ - NINT;
    localparam int BW   = (NINT > 1) ? $clog2(NINT) : 1;
    localparam int SW   = (NSHR > 1) ? $clog2(NSHR) : 1;

    logic [NINT-1:0][NCPU-1:0][PRIO_W-1:0] banked;
    logic [NSHR-1:0][PRIO_W-1:0]           shared;

    logic          wr_low, rd_low;
    logic [BW-1:0] wr_bidx, rd_bidx;
    logic [SW-1:0] wr_sidx, rd_sidx;

    always_comb begin
        wr_low  = wr_irq < IRQ_W'(NINT);
        rd_low  = rd_irq < IRQ_W'(NINT);
        wr_bidx = BW'(wr_irq);
        rd_bidx = BW'(rd_irq);
        wr_sidx = SW'(wr_irq - IRQ_W'(NINT));
        rd_sidx = SW'(rd_irq - IRQ_W'(NINT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            banked <= '0;
            shared <= '0;
        end else if (wr_vld) begin
            if (wr_low) begin
                banked[wr_bidx][wr_cpu] <= wr_val;
            end else begin
                shared[wr_sidx] <= wr_val;
            end
        end
    end

    assign rd_val = rd_low ? banked[rd_bidx][rd_cpu] : shared[rd_sidx];

endmodule

// File: rtl/irq_query_view.sv
module irq_query_view
    import irq_trk_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NIRQ  = 64,
    parameter int REV_W = 8,
    parameter int IRQ_W = $clog2(NIRQ),
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic [NIRQ-1:0][NCPU-1:0] st_en,
    input  logic [NIRQ-1:0][NCPU-1:0] st_pend,
    input  logic [NIRQ-1:0][NCPU-1:0] st_act,
    input  logic [NIRQ-1:0][NCPU-1:0] st_lvl,
    input  logic [NIRQ-1:0][NCPU-1:0] st_grp,
    input  logic [NIRQ-1:0]           st_edge,
    input  logic [1:0]                grp_en,
    input  logic [REV_W-1:0]          rev_code,
    input  logic [IRQ_W-1:0]          q_irq,
    input  logic [CPU_W-1:0]          q_cpu,
    output logic                      q_pending,
    output logic                      q_active,
    output logic                      q_enabled,
    output logic                      q_group,
    output logic                      q_fwd
);

    logic legacy;
    logic live_lvl;

    always_comb begin
        legacy    = rev_code == REV_W'(LEGACY_REV);
        live_lvl  = !legacy && !st_edge[q_irq] && st_lvl[q_irq][q_cpu];
        q_pending = st_pend[q_irq][q_cpu] || live_lvl;
        q_active  = st_act[q_irq][q_cpu];
        q_enabled = st_en[q_irq][q_cpu];
        q_group   = st_grp[q_irq][q_cpu];
        q_fwd     = q_pending && q_enabled && grp_en[q_group];
    end

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
    import irq_trk_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NIRQ   = 64,
    parameter int NINT   = 32,
    parameter int PRIO_W = 8,
    parameter int REV_W  = 8,
    localparam int IRQ_W = $clog2(NIRQ),
    localparam int CPU_W = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REV_W-1:0]  rev_code,
    input  logic              ctl_vld,
    input  logic [1:0]        ctl_data,
    input  logic              set_vld,
    input  logic [1:0]        set_kind,
    input  logic [IRQ_W-1:0]  set_irq,
    input  logic [NCPU-1:0]   set_mask,
    input  logic              clr_vld,
    input  logic [1:0]        clr_kind,
    input  logic [IRQ_W-1:0]  clr_irq,
    input  logic [NCPU-1:0]   clr_mask,
    input  logic              ack_vld,
    input  logic [IRQ_W-1:0]  ack_irq,
    input  logic [CPU_W-1:0]  ack_cpu,
    input  logic              lvl_vld,
    input  logic [IRQ_W-1:0]  lvl_irq,
    input  logic [NCPU-1:0]   lvl_mask,
    input  logic              lvl_val,
    input  logic              cfg_vld,
    input  logic [IRQ_W-1:0]  cfg_irq,
    input  logic              cfg_edge,
    input  logic              cfg_model,
    input  logic              pri_vld,
    input  logic [IRQ_W-1:0]  pri_irq,
    input  logic [CPU_W-1:0]  pri_cpu,
    input  logic [PRIO_W-1:0] pri_val,
    input  logic [IRQ_W-1:0]  q_irq,
    input  logic [CPU_W-1:0]  q_cpu,
    output logic              q_pending,
    output logic              q_active,
    output logic              q_enabled,
    output logic              q_group,
    output logic [PRIO_W-1:0] q_prio,
    output logic              q_fwd
);

    logic [NIRQ-1:0][NCPU-1:0] st_en, st_pend, st_act, st_lvl, st_grp;
    logic [NIRQ-1:0]           st_edge, st_model;
    logic [1:0]                grp_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_en <= 2'b00;
        end else if (ctl_vld) begin
            grp_en <= ctl_data;
        end
    end

    irq_cell_bank #(.NCPU(NCPU), .NIRQ(NIRQ)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (set_vld),
        .set_kind (st_kind_e'(set_kind)),
        .set_irq  (set_irq),
        .set_mask (set_mask),
        .clr_vld  (clr_vld),
        .clr_kind (st_kind_e'(clr_kind)),
        .clr_irq  (clr_irq),
        .clr_mask (clr_mask),
        .ack_vld  (ack_vld),
        .ack_irq  (ack_irq),
        .ack_cpu  (ack_cpu),
        .lvl_vld  (lvl_vld),
        .lvl_irq  (lvl_irq),
        .lvl_mask (lvl_mask),
        .lvl_val  (lvl_val),
        .cfg_vld  (cfg_vld),
        .cfg_irq  (cfg_irq),
        .cfg_edge (cfg_edge),
        .cfg_model(cfg_model),
        .st_en    (st_en),
        .st_pend  (st_pend),
        .st_act   (st_act),
        .st_lvl   (st_lvl),
        .st_grp   (st_grp),
        .st_edge  (st_edge),
        .st_model (st_model)
    );

    irq_prio_store #(
        .NCPU(NCPU), .NIRQ(NIRQ), .NINT(NINT), .PRIO_W(PRIO_W)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_vld(pri_vld),
        .wr_irq(pri_irq),
        .wr_cpu(pri_cpu),
        .wr_val(pri_val),
        .rd_irq(q_irq),
        .rd_cpu(q_cpu),
        .rd_val(q_prio)
    );

    irq_query_view #(.NCPU(NCPU), .NIRQ(NIRQ), .REV_W(REV_W)) u_view (
        .st_en    (st_en),
        .st_pend  (st_pend),
        .st_act   (st_act),
        .st_lvl   (st_lvl),
        .st_grp   (st_grp),
        .st_edge  (st_edge),
        .grp_en   (grp_en),
        .rev_code (rev_code),
        .q_irq    (q_irq),
        .q_cpu    (q_cpu),
        .q_pending(q_pending),
        .q_active (q_active),
        .q_enabled(q_enabled),
        .q_group  (q_group),
        .q_fwd    (q_fwd)
    );

endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
    parameter int NCPU  = 4,
    parameter int NIRQ  = 64,
    parameter int REV_W = 8,
    parameter int IRQ_W = $clog2(NIRQ),
    parameter int CPU_W = $clog2(NCPU)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [REV_W-1:0]          rev_code,
    input logic                      set_vld,
    input logic [1:0]                set_kind,
    input logic [IRQ_W-1:0]          set_irq,
    input logic [NCPU-1:0]           set_mask,
    input logic                      clr_vld,
    input logic [1:0]                clr_kind,
    input logic [IRQ_W-1:0]          clr_irq,
    input logic [NCPU-1:0]           clr_mask,
    input logic                      ack_vld,
    input logic [IRQ_W-1:0]          ack_irq,
    input logic [IRQ_W-1:0]          q_irq,
    input logic [CPU_W-1:0]          q_cpu,
    input logic                      q_pending,
    input logic [NIRQ-1:0][NCPU-1:0] st_en,
    input logic [NIRQ-1:0][NCPU-1:0] st_pend,
    input logic [NIRQ-1:0][NCPU-1:0] st_lvl,
    input logic [NIRQ-1:0]           st_edge,
    input logic [NIRQ-1:0]           st_model
);

    logic en_collide;
    assign en_collide = clr_vld && clr_kind == 2'd0 && clr_irq == set_irq;

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld && set_kind == 2'd0 && !en_collide
        |=> (st_en[$past(set_irq)] & $past(set_mask)) == $past(set_mask));

    // R2
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld && set_kind == 2'd0 && !en_collide
        |=> (st_en[$past(set_irq)] & ~$past(set_mask))
            == ($past(st_en[set_irq]) & ~$past(set_mask)));

    // R3
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vld && clr_kind == 2'd1
        |=> (st_pend[$past(clr_irq)] & $past(clr_mask)) == '0);

    // R6
    spread_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld && st_model[ack_irq]
        |=> st_pend[$past(ack_irq)] == '0);

    // R5
    legacy_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_code == '0 |-> q_pending == st_pend[q_irq][q_cpu]);

    // R4
    level_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_code != '0 && !st_edge[q_irq] && st_lvl[q_irq][q_cpu] |-> q_pending);

endmodule

bind irq_state_tracker irq_state_tracker_chk #(
    .NCPU(NCPU), .NIRQ(NIRQ), .REV_W(REV_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rev_code (rev_code),
    .set_vld  (set_vld),
    .set_kind (set_kind),
    .set_irq  (set_irq),
    .set_mask (set_mask),
    .clr_vld  (clr_vld),
    .clr_kind (clr_kind),
    .clr_irq  (clr_irq),
    .clr_mask (clr_mask),
    .ack_vld  (ack_vld),
    .ack_irq  (ack_irq),
    .q_irq    (q_irq),
    .q_cpu    (q_cpu),
    .q_pending(q_pending),
    .st_en    (st_en),
    .st_pend  (st_pend),
    .st_lvl   (st_lvl),
    .st_edge  (st_edge),
    .st_model (st_model)
);

// File: tb/tb_irq_state_tracker.sv
`timescale 1ns/1ps
module tb_irq_state_tracker;

    localparam int NC = 4;
    localparam int NI = 64;
    localparam int NB = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rev_code;
    logic       ctl_vld;
    logic [1:0] ctl_data;
    logic       set_vld, clr_vld, ack_vld, lvl_vld, cfg_vld, pri_vld;
    logic [1:0] set_kind, clr_kind;
    logic [5:0] set_irq, clr_irq, ack_irq, lvl_irq, cfg_irq, pri_irq, q_irq;
    logic [3:0] set_mask, clr_mask, lvl_mask;
    logic [1:0] ack_cpu, pri_cpu, q_cpu;
    logic       lvl_val, cfg_edge, cfg_model;
    logic [7:0] pri_val;
    logic       q_pending, q_active, q_enabled, q_group, q_fwd;
    logic [7:0] q_prio;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_state_tracker dut (
        .clk(clk), .rst_n(rst_n), .rev_code(rev_code),
        .ctl_vld(ctl_vld), .ctl_data(ctl_data),
        .set_vld(set_vld), .set_kind(set_kind), .set_irq(set_irq), .set_mask(set_mask),
        .clr_vld(clr_vld), .clr_kind(clr_kind), .clr_irq(clr_irq), .clr_mask(clr_mask),
        .ack_vld(ack_vld), .ack_irq(ack_irq), .ack_cpu(ack_cpu),
        .lvl_vld(lvl_vld), .lvl_irq(lvl_irq), .lvl_mask(lvl_mask), .lvl_val(lvl_val),
        .cfg_vld(cfg_vld), .cfg_irq(cfg_irq), .cfg_edge(cfg_edge), .cfg_model(cfg_model),
        .pri_vld(pri_vld), .pri_irq(pri_irq), .pri_cpu(pri_cpu), .pri_val(pri_val),
        .q_irq(q_irq), .q_cpu(q_cpu),
        .q_pending(q_pending), .q_active(q_active), .q_enabled(q_enabled),
        .q_group(q_group), .q_prio(q_prio), .q_fwd(q_fwd)
    );

    // behavioural reference: kind 0 enable, 1 pending, 2 active, 3 group
    bit        m_st [4][NI][NC];
    bit        m_nx [4][NI][NC];
    bit        m_lvl[NI][NC];
    bit        m_edg[NI];
    bit        m_mdl[NI];
    int        m_pb [NB][NC];
    int        m_ps [NI-NB];
    bit [1:0]  m_gen;

    task automatic model_step();
        for (int i = 0; i < NI; i++) begin
            for (int c = 0; c < NC; c++) begin
                bit nl;
                bit rise;
                nl = m_lvl[i][c];
                if (lvl_vld && lvl_irq == i && lvl_mask[c]) nl = lvl_val;
                rise = m_edg[i] && m_st[0][i][c] && nl && !m_lvl[i][c];
                for (int k = 0; k < 4; k++) begin
                    bit sb;
                    bit cb;
                    sb = set_vld && set_irq == i && set_kind == k && set_mask[c];
                    cb = clr_vld && clr_irq == i && clr_kind == k && clr_mask[c];
                    if (k == 1) begin
                        sb = sb || rise;
                        cb = cb || (ack_vld && ack_irq == i && (m_mdl[i] || ack_cpu == c));
                    end
                    m_nx[k][i][c] = cb ? 1'b0 : (m_st[k][i][c] || sb);
                end
                m_lvl[i][c] = nl;
            end
        end
        m_st = m_nx;
        if (cfg_vld) begin
            m_edg[cfg_irq] = cfg_edge;
            m_mdl[cfg_irq] = cfg_model;
        end
        if (pri_vld) begin
            if (pri_irq < NB) m_pb[pri_irq][pri_cpu] = pri_val;
            else m_ps[pri_irq - NB] = pri_val;
        end
        if (ctl_vld) m_gen = ctl_data;
    endtask

    function automatic int m_pend(int i, int c);
        return (m_st[1][i][c] || (rev_code != 0 && !m_edg[i] && m_lvl[i][c])) ? 1 : 0;
    endfunction

    function automatic int m_prio(int i, int c);
        return (i < NB) ? m_pb[i][c] : m_ps[i - NB];
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s irq=%0d cpu=%0d actual=%0d expected=%0d",
                     req, q_irq, q_cpu, act, exp);
        end
    endtask

    task automatic compare_model();
        int i;
        int c;
        int fw;
        i = q_irq;
        c = q_cpu;
        fw = (m_pend(i, c) == 1 && m_st[0][i][c] && m_gen[m_st[3][i][c]]) ? 1 : 0;
        chk("R4 model pending", q_pending, m_pend(i, c));
        chk("R2 model active",  q_active,  m_st[2][i][c]);
        chk("R2 model enable",  q_enabled, m_st[0][i][c]);
        chk("R2 model group",   q_group,   m_st[3][i][c]);
        chk("R8 model prio",    q_prio,    m_prio(i, c));
        chk("R9 model fwd",     q_fwd,     fw);
    endtask

    task automatic idle();
        ctl_vld = 0; set_vld = 0; clr_vld = 0; ack_vld = 0;
        lvl_vld = 0; cfg_vld = 0; pri_vld = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
        idle();
    endtask

    task automatic probe(int i, int c);
        q_irq = 6'(i);
        q_cpu = 2'(c);
        #1;
    endtask

    task automatic do_set(int k, int i, int m);
        set_vld = 1; set_kind = 2'(k); set_irq = 6'(i); set_mask = 4'(m);
    endtask

    task automatic do_clr(int k, int i, int m);
        clr_vld = 1; clr_kind = 2'(k); clr_irq = 6'(i); clr_mask = 4'(m);
    endtask

    task automatic do_ack(int i, int c);
        ack_vld = 1; ack_irq = 6'(i); ack_cpu = 2'(c);
    endtask

    task automatic do_lvl(int i, int m, int v);
        lvl_vld = 1; lvl_irq = 6'(i); lvl_mask = 4'(m); lvl_val = v[0];
    endtask

    task automatic do_cfg(int i, int e, int md);
        cfg_vld = 1; cfg_irq = 6'(i); cfg_edge = e[0]; cfg_model = md[0];
    endtask

    task automatic do_pri(int i, int c, int v);
        pri_vld = 1; pri_irq = 6'(i); pri_cpu = 2'(c); pri_val = 8'(v);
    endtask

    function automatic logic [5:0] pick_irq();
        return ($urandom % 2 == 0) ? 6'($urandom % 6) : 6'(NB + $urandom % 6);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rev_code = 8'd1; ctl_data = 0;
        set_kind = 0; set_irq = 0; set_mask = 0;
        clr_kind = 0; clr_irq = 0; clr_mask = 0;
        ack_irq = 0; ack_cpu = 0; lvl_irq = 0; lvl_mask = 0; lvl_val = 0;
        cfg_irq = 0; cfg_edge = 0; cfg_model = 0;
        pri_irq = 0; pri_cpu = 0; pri_val = 0; q_irq = 0; q_cpu = 0;
        idle();
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        probe(5, 0);
        chk("R1 pending", q_pending, 0);
        chk("R1 enable", q_enabled, 0);
        chk("R1 prio", q_prio, 0);
        probe(40, 3);
        chk("R1 prio shared", q_prio, 0);
        chk("R1 fwd", q_fwd, 0);

        // R2: mask-limited set
        do_set(0, 3, 4'b0101); tick();
        probe(3, 0); chk("R2 enable cpu0", q_enabled, 1);
        probe(3, 1); chk("R2 enable cpu1", q_enabled, 0);

        // R3: set and clear together
        do_set(1, 3, 4'b1111); do_clr(1, 3, 4'b0011); tick();
        probe(3, 0); chk("R3 clear wins", q_pending, 0);
        probe(3, 2); chk("R3 set kept", q_pending, 1);

        // R4 / R5: level input combining
        do_lvl(40, 4'b0010, 1); tick();
        probe(40, 1); chk("R4 level pending", q_pending, 1);
        rev_code = 0; #1;
        chk("R5 legacy ignores level", q_pending, 0);
        rev_code = 1; #1;

        // R6: acknowledge with line still high
        do_set(1, 40, 4'b0010); tick();
        do_ack(40, 1); tick();
        probe(40, 1);
        rev_code = 0; #1;
        chk("R6 latched cleared", q_pending, 0);
        rev_code = 1; #1;
        chk("R6 level still pending", q_pending, 1);
        do_lvl(40, 4'b0010, 0); tick();
        probe(40, 1); chk("R4 line dropped", q_pending, 0);

        // R6: spread flag vs single processor
        do_cfg(41, 0, 1); tick();
        do_set(1, 41, 4'b1111); tick();
        do_ack(41, 2); tick();
        probe(41, 0); chk("R6 spread clears cpu0", q_pending, 0);
        probe(41, 3); chk("R6 spread clears cpu3", q_pending, 0);
        do_set(1, 42, 4'b1111); tick();
        do_ack(42, 2); tick();
        probe(42, 0); chk("R6 other cpu kept", q_pending, 1);
        probe(42, 2); chk("R6 acking cpu cleared", q_pending, 0);

        // R7: edge capture gated by enable
        do_cfg(50, 1, 0); tick();
        do_set(0, 50, 4'b0001); tick();
        do_lvl(50, 4'b0011, 1); tick();
        probe(50, 0); chk("R7 edge latched", q_pending, 1);
        probe(50, 1); chk("R7 disabled no latch", q_pending, 0);

        // R8: banked and shared priority
        do_pri(5, 1, 8'h80); tick();
        do_pri(5, 2, 8'h40); tick();
        probe(5, 1); chk("R8 banked cpu1", q_prio, 8'h80);
        probe(5, 2); chk("R8 banked cpu2", q_prio, 8'h40);
        probe(5, 0); chk("R8 banked cpu0 untouched", q_prio, 0);
        do_pri(45, 3, 8'h33); tick();
        probe(45, 0); chk("R8 shared seen by cpu0", q_prio, 8'h33);

        // R9: group enables
        ctl_vld = 1; ctl_data = 2'b01; tick();
        do_set(1, 3, 4'b0001); tick();
        probe(3, 0); chk("R9 group0 fwd", q_fwd, 1);
        do_set(3, 3, 4'b0001); tick();
        probe(3, 0); chk("R9 group1 blocked", q_fwd, 0);
        ctl_vld = 1; ctl_data = 2'b11; tick();
        probe(3, 0); chk("R9 group1 fwd", q_fwd, 1);

        // random traffic compared every cycle
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 3 == 0) do_set($urandom % 4, pick_irq(), $urandom % 16);
            if ($urandom % 3 == 0) do_clr($urandom % 4, pick_irq(), $urandom % 16);
            if ($urandom % 4 == 0) do_ack(pick_irq(), $urandom % 4);
            if ($urandom % 3 == 0) do_lvl(pick_irq(), $urandom % 16, $urandom % 2);
            if ($urandom % 12 == 0) do_cfg(pick_irq(), $urandom % 2, $urandom % 2);
            if ($urandom % 6 == 0) do_pri(pick_irq(), $urandom % 4, $urandom % 256);
            if ($urandom % 20 == 0) begin ctl_vld = 1; ctl_data = 2'($urandom % 4); end
            if ($urandom % 50 == 0) rev_code = ($urandom % 2 == 0) ? 8'd0 : 8'd2;
            q_irq = pick_irq();
            q_cpu = 2'($urandom % 4);
            tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule